// File: doc/BRIEF.md
# PCI-to-PCI Bridge Window Configuration Registers

This block is the register file behind the bridge-specific part of a type-1 configuration header. It keeps the three bus numbers, the secondary latency timer, the interrupt and bridge-control word, and three address windows: I/O, memory and prefetchable memory. A host issues dword-aligned configuration accesses through a register port that has a dword index, 32-bit write data and a write strobe. Read data is returned combinationally for the index presented.

Each window is also driven out as a pair of full-width addresses, an inclusive base and an exclusive limit, so that a forwarding decoder can compare transaction addresses against them directly. Parameters define capability masks that select the writable bits of every base and limit register. The low nibble of each mask is the addressing-width code that the register reports. A code of 1 means wide addressing: 32-bit I/O or 64-bit prefetchable memory. Only when that code is 1 do the upper-half registers accept writes.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset, the bus numbers, latency timer, bridge control, interrupt line and all upper-half registers are 0. Every base and limit register holds 0 except for its low nibble, which holds its mask's low nibble. Every window base address is 0. Each window limit address equals its granularity: 0x1000 for I/O and 0x100000 for both memory windows.
- R2: Dword index 6 holds the primary bus in bits 7:0, the secondary bus in 15:8, the subordinate bus in 23:16 and the latency timer in 31:24, for both reads and writes. The three bus numbers also appear on their own output ports.
- R3: A write to index 6 gives the latency timer the value (old & ~LAT_WMASK) | (new & LAT_WMASK). With a mask of 0 the timer is read-only.
- R4: Every base or limit register stores (written & CAP) | CAP[3:0]. Its low nibble therefore always equals the low nibble of its mask, CAP.
- R5: The I/O base address is {io upper base[15:0], io base[7:4], 12'h000}. The I/O limit address is {io upper limit[15:0], io limit[7:4], 12'h000} + 0x1000, computed modulo 2^32.
- R6: The I/O upper-half registers are at index 12: the base in bits 15:0 and the limit in bits 31:16. The prefetchable upper base is at index 10 and the prefetchable upper limit at index 11, each 32 bits. An upper-half register takes a write only when the low nibble of its base or limit register is 1. Otherwise it stays 0, reads 0 and leaves the window addresses unchanged.
- R7: Index 8 holds the memory base in bits 15:0 and the memory limit in bits 31:16. The memory base address is {base[15:4], 20'h0}, and the limit address is {limit[15:4], 20'h0} + 0x100000, modulo 2^32. Index 9 holds the prefetchable base and limit in the same layout, and its addresses are formed the same way with the upper halves prepended, modulo 2^64.
- R8: Index 7 holds the I/O base in bits 7:0 and the I/O limit in bits 15:8. Bits 31:16, the secondary status, read 0, and writes to them are ignored.
- R9: Index 15 reads as {bridge control[15:0], INT_PIN[7:0], interrupt line[7:0]}. The bridge control and the interrupt line are writable. The pin comes from a parameter and is read-only.
- R10: Any index other than 6 to 12 and 15 reads 0, and writes to it change no register.
- R11: A write becomes visible on the read data and on the window outputs after the rising edge on which the write strobe is sampled. Read data follows the index with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dw | input | 6 | Dword index of the access (byte offset / 4) |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw |
| pri_bus | output | 8 | Primary bus number |
| sec_bus | output | 8 | Secondary bus number |
| sub_bus | output | 8 | Subordinate bus number |
| io_base_addr | output | 32 | First address of the I/O window |
| io_limit_addr | output | 32 | First address above the I/O window |
| mem_base_addr | output | 32 | First address of the memory window |
| mem_limit_addr | output | 32 | First address above the memory window |
| pf_base_addr | output | 64 | First address of the prefetchable window |
| pf_limit_addr | output | 64 | First address above the prefetchable window |

## Verification
Two instances are driven side by side: one advertises wide addressing and a partial latency mask, and the other advertises narrow addressing and a read-only timer. A wrongly masked or wrongly coded base or limit register is visible on the read data and on the window outputs one edge after the write that caused it. A sweep over all values of a byte register exposes any bit stuck or leaking through a mask. An upper half that accepts a write it should have refused shows up at once in the high bits of the narrow instance's window addresses, and a decode fault at an unimplemented index shows up as nonzero read data or as a change in a neighbouring register.

// File: rtl/bcfg_pkg.sv
// Package: bcfg_pkg
// Shared dword indices of the bridge configuration window registers.
// Assumes the host presents dword indices (byte offset / 4).
package bcfg_pkg;

    localparam int DW_IDX_W = 6;

    typedef enum logic [DW_IDX_W-1:0] {
        DW_BUS    = 6'd6,
        DW_IO     = 6'd7,
        DW_MEM    = 6'd8,
        DW_PF     = 6'd9,
        DW_PF_BUP = 6'd10,
        DW_PF_LUP = 6'd11,
        DW_IO_UP  = 6'd12,
        DW_INTR   = 6'd15
    } bcfg_dw_e;

    // True when the index decodes to an implemented register.
    function automatic logic bcfg_is_impl(input logic [DW_IDX_W-1:0] idx);
        return (idx >= 6'd6 && idx <= 6'd12) || idx == 6'd15;
    endfunction

endpackage

// File: rtl/bcfg_window.sv
// Module: bcfg_window
// One address window: a base/limit register pair, an optional upper-half
// register pair, and the derived base and exclusive limit addresses.
// Assumes: LW >= 8, CAP[3:0] is the addressing-width code; UW = 0 means the
// window has no upper half (its upper ports are ignored and driven 0).
module bcfg_window #(
    parameter int          LW    = 8,
    parameter int          UW    = 16,
    parameter int          SHIFT = 8,
    parameter logic [LW-1:0] CAP = '1,
    localparam int         UPW   = (UW > 0) ? UW : 1,
    localparam int         AW    = UW + LW + SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_base,
    input  logic           wr_lim,
    input  logic [LW-1:0]  base_d,
    input  logic [LW-1:0]  lim_d,
    input  logic           wr_base_up,
    input  logic           wr_lim_up,
    input  logic [UPW-1:0] base_up_d,
    input  logic [UPW-1:0] lim_up_d,
    output logic [LW-1:0]  base_lo,
    output logic [LW-1:0]  lim_lo,
    output logic [UPW-1:0] base_up,
    output logic [UPW-1:0] lim_up,
    output logic [AW-1:0]  base_addr,
    output logic [AW-1:0]  lim_addr
);
    localparam int          FILL   = SHIFT + 4;
    localparam logic [3:0]  CODE   = CAP[3:0];
    localparam logic [LW-1:0] RST_LO = {{(LW-4){1'b0}}, CODE};
    localparam logic [AW-1:0] GRAN = {{(AW-1){1'b0}}, 1'b1} << FILL;

    logic [LW-1:0] base_q, lim_q;
    logic [AW-1:0] lim_raw;

    // Base and limit low registers: masked write, code nibble forced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_LO;
            lim_q  <= RST_LO;
        end else begin
            if (wr_base) base_q <= (base_d & CAP) | RST_LO;
            if (wr_lim)  lim_q  <= (lim_d  & CAP) | RST_LO;
        end
    end

    assign base_lo = base_q;
    assign lim_lo  = lim_q;

    generate
        if (UW > 0) begin : g_upper
            logic [UW-1:0] bup_q, lup_q;

            // Upper halves: writable only while the register's code is 1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bup_q <= '0;
                    lup_q <= '0;
                end else begin
                    if (wr_base_up && base_q[3:0] == 4'd1) bup_q <= base_up_d;
                    if (wr_lim_up  && lim_q[3:0]  == 4'd1) lup_q <= lim_up_d;
                end
            end

            assign base_up   = bup_q;
            assign lim_up    = lup_q;
            assign base_addr = {bup_q, base_q[LW-1:4], {FILL{1'b0}}};
            assign lim_raw   = {lup_q, lim_q[LW-1:4],  {FILL{1'b0}}};

            assert_up_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (base_q[3:0] != 4'd1) |=> (bup_q == '0 && lup_q == '0));
        end else begin : g_no_upper
            logic unused_up;
            assign unused_up = &{1'b0, wr_base_up, wr_lim_up, base_up_d, lim_up_d};
            assign base_up   = '0;
            assign lim_up    = '0;
            assign base_addr = {base_q[LW-1:4], {FILL{1'b0}}};
            assign lim_raw   = {lim_q[LW-1:4],  {FILL{1'b0}}};
        end
    endgenerate

    assign lim_addr = lim_raw + GRAN;

    assert_lo_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base |=> base_q == (($past(base_d) & CAP) | RST_LO));

    assert_code_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lim |=> $stable(lim_q));

    assert_lim_above_gran_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lim_addr[FILL-1:0] == '0);

endmodule

// File: rtl/bridge_cfg_regs.sv
// Module: bridge_cfg_regs
// Bridge-specific configuration header registers: bus numbers, latency
// timer, interrupt/bridge control and three address windows with decoded
// full-width boundaries. Assumes one dword access per cycle, combinational
// reads and writes committed on the clock edge that samples cfg_wr.
module bridge_cfg_regs
    import bcfg_pkg::*;
#(
    parameter logic [7:0]  LAT_WMASK = 8'hF8,
    parameter logic [7:0]  IO_CAP    = 8'hF1,
    parameter logic [15:0] MEM_CAP   = 16'hFFF0,
    parameter logic [15:0] PF_CAP    = 16'hFFF1,
    parameter logic [7:0]  INT_PIN   = 8'h01,
    parameter int          DATA_W    = 32,
    localparam int         IO_AW     = 32,
    localparam int         MEM_AW    = 32,
    localparam int         PF_AW     = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW_IDX_W-1:0] cfg_dw,
    input  logic                cfg_wr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic [7:0]          pri_bus,
    output logic [7:0]          sec_bus,
    output logic [7:0]          sub_bus,
    output logic [IO_AW-1:0]    io_base_addr,
    output logic [IO_AW-1:0]    io_limit_addr,
    output logic [MEM_AW-1:0]   mem_base_addr,
    output logic [MEM_AW-1:0]   mem_limit_addr,
    output logic [PF_AW-1:0]    pf_base_addr,
    output logic [PF_AW-1:0]    pf_limit_addr
);
    logic [7:0]  pri_q, sec_q, sub_q, lat_q, line_q;
    logic [15:0] brctl_q;
    logic wr_bus, wr_io, wr_mem, wr_pf, wr_pf_bup, wr_pf_lup, wr_io_up, wr_intr;

    logic [7:0]  io_b, io_l;
    logic [15:0] io_bu, io_lu, mem_b, mem_l, pf_b, pf_l;
    logic        mem_bu, mem_lu;
    logic [31:0] pf_bu, pf_lu;

    // Write decode: one strobe per implemented dword.
    always_comb begin
        wr_bus    = cfg_wr && cfg_dw == DW_BUS;
        wr_io     = cfg_wr && cfg_dw == DW_IO;
        wr_mem    = cfg_wr && cfg_dw == DW_MEM;
        wr_pf     = cfg_wr && cfg_dw == DW_PF;
        wr_pf_bup = cfg_wr && cfg_dw == DW_PF_BUP;
        wr_pf_lup = cfg_wr && cfg_dw == DW_PF_LUP;
        wr_io_up  = cfg_wr && cfg_dw == DW_IO_UP;
        wr_intr   = cfg_wr && cfg_dw == DW_INTR;
    end

    // Bus numbers, masked latency timer, interrupt line and bridge control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q   <= '0;
            sec_q   <= '0;
            sub_q   <= '0;
            lat_q   <= '0;
            line_q  <= '0;
            brctl_q <= '0;
        end else begin
            if (wr_bus) begin
                pri_q <= cfg_wdata[7:0];
                sec_q <= cfg_wdata[15:8];
                sub_q <= cfg_wdata[23:16];
                lat_q <= (lat_q & ~LAT_WMASK) | (cfg_wdata[31:24] & LAT_WMASK);
            end
            if (wr_intr) begin
                line_q  <= cfg_wdata[7:0];
                brctl_q <= cfg_wdata[31:16];
            end
        end
    end

    assign pri_bus = pri_q;
    assign sec_bus = sec_q;
    assign sub_bus = sub_q;

    bcfg_window #(.LW(8), .UW(16), .SHIFT(8), .CAP(IO_CAP)) u_io (
        .clk(clk), .rst_n(rst_n),
        .wr_base(wr_io), .wr_lim(wr_io),
        .base_d(cfg_wdata[7:0]), .lim_d(cfg_wdata[15:8]),
        .wr_base_up(wr_io_up), .wr_lim_up(wr_io_up),
        .base_up_d(cfg_wdata[15:0]), .lim_up_d(cfg_wdata[31:16]),
        .base_lo(io_b), .lim_lo(io_l), .base_up(io_bu), .lim_up(io_lu),
        .base_addr(io_base_addr), .lim_addr(io_limit_addr)
    );

    bcfg_window #(.LW(16), .UW(0), .SHIFT(16), .CAP(MEM_CAP)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_base(wr_mem), .wr_lim(wr_mem),
        .base_d(cfg_wdata[15:0]), .lim_d(cfg_wdata[31:16]),
        .wr_base_up(1'b0), .wr_lim_up(1'b0),
        .base_up_d(1'b0), .lim_up_d(1'b0),
        .base_lo(mem_b), .lim_lo(mem_l), .base_up(mem_bu), .lim_up(mem_lu),
        .base_addr(mem_base_addr), .lim_addr(mem_limit_addr)
    );

    bcfg_window #(.LW(16), .UW(32), .SHIFT(16), .CAP(PF_CAP)) u_pf (
        .clk(clk), .rst_n(rst_n),
        .wr_base(wr_pf), .wr_lim(wr_pf),
        .base_d(cfg_wdata[15:0]), .lim_d(cfg_wdata[31:16]),
        .wr_base_up(wr_pf_bup), .wr_lim_up(wr_pf_lup),
        .base_up_d(cfg_wdata), .lim_up_d(cfg_wdata),
        .base_lo(pf_b), .lim_lo(pf_l), .base_up(pf_bu), .lim_up(pf_lu),
        .base_addr(pf_base_addr), .lim_addr(pf_limit_addr)
    );

    // Read mux: status half-word and unimplemented indices return zero.
    always_comb begin
        case (cfg_dw)
            DW_BUS:    cfg_rdata = {lat_q, sub_q, sec_q, pri_q};
            DW_IO:     cfg_rdata = {16'h0000, io_l, io_b};
            DW_MEM:    cfg_rdata = {mem_l, mem_b};
            DW_PF:     cfg_rdata = {pf_l, pf_b};
            DW_PF_BUP: cfg_rdata = pf_bu;
            DW_PF_LUP: cfg_rdata = pf_lu;
            DW_IO_UP:  cfg_rdata = {io_lu, io_bu};
            DW_INTR:   cfg_rdata = {brctl_q, INT_PIN, line_q};
            default:   cfg_rdata = '0;
        endcase
    end

    assert_lat_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bus |=> lat_q == (($past(lat_q) & ~LAT_WMASK) | ($past(cfg_wdata[31:24]) & LAT_WMASK)));

    assert_lat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_bus |=> $stable(lat_q));

    assert_status_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw == DW_IO) |-> cfg_rdata[31:16] == 16'h0000);

    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bcfg_is_impl(cfg_dw) |-> cfg_rdata == '0);

    assert_mem_no_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_bu == 1'b0 && mem_lu == 1'b0);

    assert_bus_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bus |=> sec_q == $past(cfg_wdata[15:8]));

endmodule

// File: tb/sim_bridge_cfg_regs.sv
`timescale 1ns/1ps
module sim_bridge_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;

    logic [31:0] rd0, rd1;
    logic [7:0]  pb0, sb0, ub0, pb1, sb1, ub1;
    logic [31:0] iob0, iol0, mb0, ml0, iob1, iol1, mb1, ml1;
    logic [63:0] pfb0, pfl0, pfb1, pfl1;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // Wide configuration: 32-bit I/O, 64-bit prefetchable, partial latency mask.
    bridge_cfg_regs #(.LAT_WMASK(8'hF8), .IO_CAP(8'hF1), .MEM_CAP(16'hFFF0),
                      .PF_CAP(16'hFFF1), .INT_PIN(8'h01)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd0),
        .pri_bus(pb0), .sec_bus(sb0), .sub_bus(ub0),
        .io_base_addr(iob0), .io_limit_addr(iol0),
        .mem_base_addr(mb0), .mem_limit_addr(ml0),
        .pf_base_addr(pfb0), .pf_limit_addr(pfl0));

    // Narrow configuration: 16-bit I/O, 32-bit prefetchable, read-only timer.
    bridge_cfg_regs #(.LAT_WMASK(8'h00), .IO_CAP(8'hF0), .MEM_CAP(16'hFFF0),
                      .PF_CAP(16'hFFF0), .INT_PIN(8'h02)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd1),
        .pri_bus(pb1), .sec_bus(sb1), .sub_bus(ub1),
        .io_base_addr(iob1), .io_limit_addr(iol1),
        .mem_base_addr(mb1), .mem_limit_addr(ml1),
        .pf_base_addr(pfb1), .pf_limit_addr(pfl1));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Write one dword; returns at a falling edge after the commit edge.
    task automatic wr(input logic [5:0] dw, input logic [31:0] d);
        @(negedge clk);
        cfg_dw = dw; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Present an index; read data is combinational.
    task automatic rd(input logic [5:0] dw);
        cfg_dw = dw;
        #0.5;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  lat_exp;
        logic [15:0] val, nv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of registers and windows.
        rd(6'd6);  chk("R1 bus dword u0", rd0, 0);
        rd(6'd7);  chk("R1 io dword u0", rd0, 32'h0000_0101);
                   chk("R1 io dword u1", rd1, 32'h0);
        rd(6'd9);  chk("R1 pf dword u0", rd0, 32'h0001_0001);
                   chk("R1 pf dword u1", rd1, 32'h0);
        rd(6'd12); chk("R1 io upper u0", rd0, 32'h0);
        chk("R1 io base u0", iob0, 0);
        chk("R1 io limit u0", iol0, 32'h1000);
        chk("R1 mem limit u1", ml1, 32'h0010_0000);
        chk("R1 pf limit u0", pfl0, 64'h10_0000);
        chk("R1 pf base u0", pfb0, 0);

        // R2 R3: bus packing and latency mask sweep.
        lat_exp = 8'h00;
        for (int v = 0; v < 256; v++) begin
            wr(6'd6, {v[7:0], 8'h5A ^ v[7:0], ~v[7:0], v[7:0]});
            lat_exp = (lat_exp & 8'h07) | (v[7:0] & 8'hF8);
            rd(6'd6);
            chk($sformatf("R3 lat u0 v=%0d", v), rd0[31:24], lat_exp);
            chk($sformatf("R3 lat read-only u1 v=%0d", v), rd1[31:24], 8'h00);
            chk($sformatf("R2 bus dword u0 v=%0d", v), rd0[23:0],
                {8'h5A ^ v[7:0], ~v[7:0], v[7:0]});
            chk($sformatf("R2 bus ports u1 v=%0d", v), {ub1, sb1, pb1},
                {8'h5A ^ v[7:0], ~v[7:0], v[7:0]});
        end

        // R4 R5 R8 R11: I/O base/limit sweep, status ignored.
        for (int v = 0; v < 256; v++) begin
            wr(6'd7, {16'hBEEF, ~v[7:0], v[7:0]});
            rd(6'd7);
            chk($sformatf("R8 io dword u0 v=%0d", v), rd0,
                {16'h0000, (~v[7:0] & 8'hF0) | 8'h01, (v[7:0] & 8'hF0) | 8'h01});
            chk($sformatf("R4 io dword u1 v=%0d", v), rd1,
                {16'h0000, ~v[7:0] & 8'hF0, v[7:0] & 8'hF0});
            chk($sformatf("R5 io base u0 v=%0d", v), iob0, {16'h0, v[7:4], 12'h0});
            chk($sformatf("R5 io limit u1 v=%0d", v), iol1,
                {16'h0, ~v[7:4], 12'h0} + 32'h1000);
        end

        // R6: I/O upper halves (last base byte F1, limit byte 01 on u0).
        wr(6'd12, 32'h1234_ABCD);
        rd(6'd12);
        chk("R6 io upper u0", rd0, 32'h1234_ABCD);
        chk("R6 io upper ignored u1", rd1, 32'h0);
        chk("R6 io base u0", iob0, 32'hABCD_F000);
        chk("R6 io limit u0", iol0, 32'h1234_1000);
        chk("R6 io base u1", iob1, 32'h0000_F000);
        chk("R6 io limit u1", iol1, 32'h0000_1000);

        // R7: memory window sweep.
        for (int i = 0; i < 256; i++) begin
            val = {i[7:0], i[7:0] ^ 8'h5A};
            nv  = ~val;
            wr(6'd8, {nv, val});
            rd(6'd8);
            chk($sformatf("R7 mem dword u0 i=%0d", i), rd0, {nv & 16'hFFF0, val & 16'hFFF0});
            chk($sformatf("R7 mem base u1 i=%0d", i), mb1, {val[15:4], 20'h0});
            chk($sformatf("R7 mem limit u0 i=%0d", i), ml0, {nv[15:4], 20'h0} + 32'h10_0000);
        end

        // R6 R7: prefetchable upper halves then window sweep.
        wr(6'd10, 32'hDEAD_BEEF);
        wr(6'd11, 32'h0123_4567);
        rd(6'd10); chk("R6 pf upper base u0", rd0, 32'hDEAD_BEEF);
                   chk("R6 pf upper base ignored u1", rd1, 32'h0);
        rd(6'd11); chk("R6 pf upper limit u0", rd0, 32'h0123_4567);
                   chk("R6 pf upper limit ignored u1", rd1, 32'h0);
        for (int i = 0; i < 64; i++) begin
            val = {i[5:0], 2'b10, i[5:0] ^ 6'h2B, 2'b01};
            nv  = ~val;
            wr(6'd9, {nv, val});
            rd(6'd9);
            chk($sformatf("R4 pf dword u0 i=%0d", i), rd0,
                {(nv & 16'hFFF0) | 16'h1, (val & 16'hFFF0) | 16'h1});
            chk($sformatf("R7 pf base u0 i=%0d", i), pfb0, {32'hDEAD_BEEF, val[15:4], 20'h0});
            chk($sformatf("R7 pf limit u0 i=%0d", i), pfl0,
                {32'h0123_4567, nv[15:4], 20'h0} + 64'h10_0000);
            chk($sformatf("R6 pf base u1 i=%0d", i), pfb1, {32'h0, val[15:4], 20'h0});
        end

        // R9: interrupt / bridge control dword.
        wr(6'd15, 32'hA5C3_7E19);
        rd(6'd15);
        chk("R9 intr dword u0", rd0, 32'hA5C3_0119);
        chk("R9 intr dword u1", rd1, 32'hA5C3_0219);

        // R10: unimplemented indices read zero and disturb nothing.
        for (int dw = 0; dw < 64; dw++) begin
            if ((dw >= 6 && dw <= 12) || dw == 15) continue;
            wr(dw[5:0], 32'hFFFF_FFFF);
            rd(dw[5:0]);
            chk($sformatf("R10 unimpl read u0 dw=%0d", dw), rd0, 32'h0);
        end
        rd(6'd15); chk("R10 intr unchanged u0", rd0, 32'hA5C3_0119);
        rd(6'd6);  chk("R10 bus unchanged u1", rd1[23:0], {8'h5A ^ 8'hFF, 8'h00, 8'hFF});
        rd(6'd12); chk("R10 io upper unchanged u0", rd0, 32'h1234_ABCD);
        chk("R10 io window unchanged u0", iob0, 32'hABCD_F000);
        chk("R10 pf limit unchanged u0", pfl0[63:32], 32'h0123_4567);

        // R1: reset again clears written state.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(6'd12); chk("R1 io upper after reset u0", rd0, 32'h0);
        chk("R1 pf base after reset u0", pfb0, 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule